// File: doc/BRIEF.md
# PHY Management Register File with Autonegotiation Timer

This block holds the 32 management registers, 16 bits each, of an Ethernet PHY model. The MAC side reaches them through one 32-bit command word. The word carries an opcode, a register address and a data field. A fixed capability table says which registers can be read and which can be written. An access that the table forbids is still answered, but the answer carries an error flag.

Writing the control register can also start an autonegotiation restart. The block takes the link down straight away and clears the autonegotiation-complete status. It then counts a delay in system clock cycles. When the count runs out, the link comes back up and autonegotiation is reported as complete. The `link_up` output follows the link-status bit of the status register.

The delay is `CLK_HZ/1000*AN_MS` cycles of `clk`. With the default values this is 500 ms at 125 MHz, the shortest autonegotiation timeout the Ethernet standard allows. Line signalling, speed resolution and serial management wire timing are not part of this block.

Top module: `phy_mgmt_regs`

## Requirements
- R1: A restart begins only when a write to register 0 has both bit 12 (autonegotiation enable) and bit 9 (restart) set. A control write that lacks either bit leaves `link_up` and the status register unchanged.
- R2: When a restart begins, status bit 2 (link status) is cleared, and `link_up` is low from the clock edge that accepts the write.
- R3: When a restart begins, status bit 5 (autonegotiation complete) is cleared.
- R4: Completion takes place exactly AN_CYCLES = CLK_HZ/1000*AN_MS rising edges after the edge that accepted the triggering write. Until then the link stays down.
- R5: At completion, status bits 2 and 5 are both set and `link_up` goes high. `link_up` rises at no other time.
- R6: Reset (`rst_n` low, asynchronous) cancels any pending countdown and reloads every register from its default. No completion follows later.
- R7: Reset defaults are: register 0 = 0x1140, register 1 = 0x794D (link up, autonegotiation not complete), register 2 = 0x0141, register 4 = 0x0DE1, register 9 = 0x0E00. After reset `link_up` is 1 and `cmd_reg` is 0.
- R8: A write to a register without write capability leaves that register unchanged and sets error bit 30 in `cmd_reg`. Registers 1 (status) and 2 (ID) are read-only.
- R9: A permitted write stores the full data word after any special action. Registers 0, 4, 9, 16 and 20 are writable, and a control write that triggers a restart also reads back as written.
- R10: Command word layout: data in [15:0], address in [20:16], opcode in [27:26] (01 write, 10 read). The edge after `cmd_valid` updates `cmd_reg`: bit 28 (ready) is set, the opcode and address are echoed, and [15:0] holds the read value or the echoed write data.
- R11: A read of a register without read capability, and any opcode other than 01 or 10, sets error bit 30. For a refused read, data [15:0] is 0. Registers 6 to 8, 11 to 15, 18, 19 and 21 to 31 have no capability.
- R12: A restart during an active countdown reloads it, so completion comes AN_CYCLES edges after the latest trigger.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; it also clocks the countdown |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | One-cycle strobe that executes `cmd_word` |
| cmd_word | input | 32 | Management command: opcode, address, data |
| cmd_reg | output | 32 | Command register after execution: ready, error, echo and data |
| link_up | output | 1 | Link-status bit of the status register |

## Verification
The assertions check several relations on every cycle:
- a restart clears link and completion status on the following edge;
- completion without a new trigger sets both bits;
- the status register changes only on these two events;
- `link_up` rises only after an expiry;
- every command raises ready with its address echoed;
- a refused write raises the error bit.

Only the bench scenarios can show the rest:
- the exact completion cycle;
- the reload when a second restart arrives;
- the cancellation by reset;
- the stored defaults;
- that control writes lacking the enable or restart bit never disturb the link.

// File: rtl/phy_mgmt_pkg.sv
package phy_mgmt_pkg;

  localparam int NREGS  = 32;
  localparam int DATA_W = 16;
  localparam int ADDR_W = $clog2(NREGS);
  localparam int CMD_W  = 32;

  // register indices
  localparam int RA_CTRL  = 0;
  localparam int RA_STAT  = 1;
  localparam int RA_ID1   = 2;
  localparam int RA_ID2   = 3;
  localparam int RA_ADV   = 4;
  localparam int RA_LPA   = 5;
  localparam int RA_GCTL  = 9;
  localparam int RA_GSTAT = 10;
  localparam int RA_VCTL  = 16;
  localparam int RA_VSTAT = 17;
  localparam int RA_XCTL  = 20;

  // bit positions inside control and status
  localparam int CTRL_AN_EN   = 12;
  localparam int CTRL_AN_RST  = 9;
  localparam int STAT_AN_DONE = 5;
  localparam int STAT_LINK    = 2;

  // command word fields
  localparam int F_ADDR_LSB = 16;
  localparam int F_OP_LSB   = 26;
  localparam int F_READY    = 28;
  localparam int F_ERR      = 30;

  typedef enum logic [1:0] {
    OP_NONE  = 2'b00,
    OP_WRITE = 2'b01,
    OP_READ  = 2'b10,
    OP_RSVD  = 2'b11
  } mgmt_op_e;

  function automatic logic [DATA_W-1:0] reg_default(int a);
    case (a)
      RA_CTRL: return 16'h1140;
      RA_STAT: return 16'h794D;
      RA_ID1:  return 16'h0141;
      RA_ID2:  return 16'h0C20;
      RA_ADV:  return 16'h0DE1;
      RA_GCTL: return 16'h0E00;
      RA_VCTL: return 16'h0360;
      RA_XCTL: return 16'h0D60;
      default: return '0;
    endcase
  endfunction

  function automatic logic reg_can_read(int a);
    case (a)
      RA_CTRL, RA_STAT, RA_ID1, RA_ID2, RA_ADV, RA_LPA,
      RA_GCTL, RA_GSTAT, RA_VCTL, RA_VSTAT, RA_XCTL: return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

  function automatic logic reg_can_write(int a);
    case (a)
      RA_CTRL, RA_ADV, RA_GCTL, RA_VCTL, RA_XCTL: return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

  // countdown length in clock cycles, never below one
  function automatic int unsigned an_cycles(int unsigned hz, int unsigned ms);
    int unsigned c;
    c = (hz / 1000) * ms;
    return (c == 0) ? 1 : c;
  endfunction

  function automatic logic is_an_restart(logic [DATA_W-1:0] d);
    return d[CTRL_AN_EN] & d[CTRL_AN_RST];
  endfunction

  function automatic logic [CMD_W-1:0] pack_resp(mgmt_op_e op, logic [ADDR_W-1:0] a,
                                                 logic [DATA_W-1:0] d, logic err);
    logic [CMD_W-1:0] r;
    r = '0;
    r[DATA_W-1:0] = d;
    r[F_ADDR_LSB +: ADDR_W] = a;
    r[F_OP_LSB +: 2] = op;
    r[F_READY] = 1'b1;
    r[F_ERR] = err;
    return r;
  endfunction

endpackage

// File: rtl/phy_an_timer.sv
module phy_an_timer
  import phy_mgmt_pkg::*;
#(
  parameter int unsigned CYCLES = 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic expire,
  output logic busy
);
  localparam int CNT_W = (CYCLES > 1) ? $clog2(CYCLES) : 1;
  localparam logic [CNT_W-1:0] LOAD = CNT_W'(CYCLES - 1);

  logic [CNT_W-1:0] cnt_q;
  logic             busy_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else if (start) begin
      busy_q <= 1'b1;
      cnt_q  <= LOAD;
    end else if (busy_q) begin
      if (cnt_q == '0) busy_q <= 1'b0;
      else             cnt_q  <= cnt_q - 1'b1;
    end
  end

  assign busy   = busy_q;
  assign expire = busy_q && (cnt_q == '0);

  p_cnt_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |-> (cnt_q <= LOAD));
  p_start_arms_r12: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (busy_q && cnt_q == LOAD));
  p_expire_ends_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (expire && !start) |=> !busy_q);

endmodule

// File: rtl/phy_reg_file.sv
module phy_reg_file
  import phy_mgmt_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  input  logic              an_expire,
  output logic [DATA_W-1:0] rd_data,
  output logic              an_start,
  output logic              link_up
);
  localparam logic [DATA_W-1:0] STAT_EVT_MASK =
    DATA_W'((1 << STAT_AN_DONE) | (1 << STAT_LINK));

  logic [DATA_W-1:0] regs [NREGS];
  logic [DATA_W-1:0] stat_q;

  // special action of the control register
  assign an_start = wr_en && (wr_addr == ADDR_W'(RA_CTRL)) && is_an_restart(wr_data);

  for (genvar i = 0; i < NREGS; i++) begin : g_reg
    if (i == RA_STAT) begin : g_stat
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)         stat_q <= reg_default(i);
        else if (an_start)  stat_q <= stat_q & ~STAT_EVT_MASK;
        else if (an_expire) stat_q <= stat_q | STAT_EVT_MASK;
      end
      assign regs[i] = stat_q;
    end else if (reg_can_write(i)) begin : g_rw
      logic [DATA_W-1:0] q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                                     q <= reg_default(i);
        else if (wr_en && wr_addr == ADDR_W'(i))        q <= wr_data;
      end
      assign regs[i] = q;
    end else begin : g_const
      assign regs[i] = reg_default(i);
    end
  end

  assign rd_data = regs[rd_addr];
  assign link_up = stat_q[STAT_LINK];

  p_start_drops_link_r2: assert property (@(posedge clk) disable iff (!rst_n)
    an_start |=> !link_up);
  p_start_clears_done_r3: assert property (@(posedge clk) disable iff (!rst_n)
    an_start |=> !stat_q[STAT_AN_DONE]);
  p_expire_sets_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (an_expire && !an_start) |=> (stat_q[STAT_LINK] && stat_q[STAT_AN_DONE]));
  p_status_ro_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!an_start && !an_expire) |=> $stable(stat_q));
  p_ctrl_stores_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == ADDR_W'(RA_CTRL)) |=> (regs[RA_CTRL] == $past(wr_data)));

endmodule

// File: rtl/phy_cmd_port.sv
module phy_cmd_port
  import phy_mgmt_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  input  logic [CMD_W-1:0]  cmd_word,
  input  logic [DATA_W-1:0] rd_data,
  output logic              wr_en,
  output logic [ADDR_W-1:0] acc_addr,
  output logic [DATA_W-1:0] wr_data,
  output logic [CMD_W-1:0]  cmd_reg
);
  mgmt_op_e          op;
  logic              is_wr, is_rd, bad_op, can_r, can_w, err;
  logic [DATA_W-1:0] resp_data;
  logic              unused_fields;

  assign op       = mgmt_op_e'(cmd_word[F_OP_LSB +: 2]);
  assign acc_addr = cmd_word[F_ADDR_LSB +: ADDR_W];
  assign wr_data  = cmd_word[DATA_W-1:0];
  assign unused_fields = ^{cmd_word[CMD_W-1:F_OP_LSB+2], cmd_word[F_OP_LSB-1:F_ADDR_LSB+ADDR_W]};

  assign is_wr  = (op == OP_WRITE);
  assign is_rd  = (op == OP_READ);
  assign bad_op = !is_wr && !is_rd;
  assign can_r  = reg_can_read(int'(acc_addr));
  assign can_w  = reg_can_write(int'(acc_addr));

  assign wr_en = cmd_valid && is_wr && can_w;
  assign err   = bad_op || (is_wr && !can_w) || (is_rd && !can_r);

  always_comb begin
    if (is_rd) resp_data = can_r ? rd_data : '0;
    else       resp_data = wr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         cmd_reg <= '0;
    else if (cmd_valid) cmd_reg <= pack_resp(op, acc_addr, resp_data, err);
  end

  p_ready_echo_r10: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |=> (cmd_reg[F_READY] &&
                   cmd_reg[F_ADDR_LSB +: ADDR_W] == $past(cmd_word[F_ADDR_LSB +: ADDR_W])));
  p_wr_denied_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && is_wr && !can_w) |=> cmd_reg[F_ERR]);

endmodule

// File: rtl/phy_mgmt_regs.sv
module phy_mgmt_regs
  import phy_mgmt_pkg::*;
#(
  parameter int unsigned CLK_HZ = 125_000_000,
  parameter int unsigned AN_MS  = 500
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cmd_valid,
  input  logic [31:0] cmd_word,
  output logic [31:0] cmd_reg,
  output logic        link_up
);
  localparam int unsigned AN_CYCLES = an_cycles(CLK_HZ, AN_MS);

  logic              wr_en, an_start, an_expire, an_busy;
  logic [ADDR_W-1:0] acc_addr;
  logic [DATA_W-1:0] wr_data, rd_data;

  phy_cmd_port u_port (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_word(cmd_word),
    .rd_data(rd_data), .wr_en(wr_en), .acc_addr(acc_addr), .wr_data(wr_data),
    .cmd_reg(cmd_reg)
  );

  phy_reg_file u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(acc_addr), .wr_data(wr_data),
    .rd_addr(acc_addr), .an_expire(an_expire), .rd_data(rd_data),
    .an_start(an_start), .link_up(link_up)
  );

  phy_an_timer #(.CYCLES(AN_CYCLES)) u_timer (
    .clk(clk), .rst_n(rst_n), .start(an_start), .expire(an_expire), .busy(an_busy)
  );

  p_link_rise_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(link_up) |-> $past(an_expire));
  p_link_low_busy_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (an_busy && !an_expire) |-> !link_up);

endmodule

// File: tb/test_phy_mgmt_regs.sv
module test_phy_mgmt_regs;
  localparam int CLK_PERIOD = 10;
  localparam int unsigned CLK_HZ = 20000;
  localparam int unsigned AN_MS  = 1;
  localparam int AN_N = 20;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_valid = 1'b0;
  logic [31:0] cmd_word = '0;
  wire  [31:0] cmd_reg;
  wire         link_up;

  int checks = 0;
  int errors = 0;
  logic [31:0] exp_q[$];
  string       tag_q[$];

  phy_mgmt_regs #(.CLK_HZ(CLK_HZ), .AN_MS(AN_MS)) i_phy_mgmt_regs (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_word(cmd_word),
    .cmd_reg(cmd_reg), .link_up(link_up)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [31:0] resp(logic [1:0] op, logic [4:0] a, logic [15:0] d, logic err);
    return {1'b0, err, 1'b0, 1'b1, op, 5'b0, a, d};
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic issue(logic [1:0] op, logic [4:0] a, logic [15:0] d,
                       logic [15:0] exp_d, logic err, string tag);
    exp_q.push_back(resp(op, a, exp_d, err));
    tag_q.push_back(tag);
    @(negedge clk);
    cmd_word  = {4'b0, op, 5'b0, a, d};
    cmd_valid = 1'b1;
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic rd(logic [4:0] a, logic [15:0] exp_d, logic err, string tag);
    issue(2'b10, a, 16'h0, exp_d, err, tag);
  endtask

  task automatic wr(logic [4:0] a, logic [15:0] d, logic err, string tag);
    issue(2'b01, a, d, d, err, tag);
  endtask

  task automatic pulse_reset();
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic summary();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  // scoreboard monitor
  initial begin
    forever begin
      @(posedge clk);
      if (cmd_valid) begin
        @(negedge clk);
        if (exp_q.size() == 0) check("R10 unexpected response", cmd_reg, 32'h0);
        else check(tag_q.pop_front(), cmd_reg, exp_q.pop_front());
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual running expected finished");
    summary();
  end

  initial begin
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R7 link_up after reset", {31'b0, link_up}, 32'h1);
    check("R7 cmd_reg after reset", cmd_reg, 32'h0);

    rd(5'd0, 16'h1140, 1'b0, "R7 control default");
    rd(5'd1, 16'h794D, 1'b0, "R7 status default");
    rd(5'd2, 16'h0141, 1'b0, "R7 id default");
    rd(5'd9, 16'h0E00, 1'b0, "R7 gig control default");
    rd(5'd4, 16'h0DE1, 1'b0, "R7 advert default");

    wr(5'd4, 16'h01E1, 1'b0, "R9 advert write");
    rd(5'd4, 16'h01E1, 1'b0, "R9 advert readback");

    wr(5'd1, 16'hFFFF, 1'b1, "R8 status write refused");
    rd(5'd1, 16'h794D, 1'b0, "R8 status unchanged");
    wr(5'd2, 16'h1234, 1'b1, "R8 id write refused");
    rd(5'd2, 16'h0141, 1'b0, "R8 id unchanged");

    rd(5'd31, 16'h0000, 1'b1, "R11 read unreadable");
    issue(2'b11, 5'd0, 16'hABCD, 16'hABCD, 1'b1, "R11 reserved opcode");
    issue(2'b00, 5'd4, 16'h5555, 16'h5555, 1'b1, "R11 null opcode");
    rd(5'd4, 16'h01E1, 1'b0, "R11 bad opcode wrote nothing");

    // R1: restart bit alone, enable bit alone
    wr(5'd0, 16'h0200, 1'b0, "R1 restart without enable");
    wr(5'd0, 16'h1000, 1'b0, "R1 enable without restart");
    repeat (AN_N + 5) @(posedge clk);
    @(negedge clk);
    check("R1 link stays up", {31'b0, link_up}, 32'h1);
    rd(5'd1, 16'h794D, 1'b0, "R1 status untouched");

    // R2/R4/R5 exact timing
    wr(5'd0, 16'h1200, 1'b0, "R9 control restart write");
    check("R2 link down after trigger", {31'b0, link_up}, 32'h0);
    repeat (AN_N - 1) @(posedge clk);
    @(negedge clk);
    check("R4 still down one cycle before", {31'b0, link_up}, 32'h0);
    @(posedge clk);
    @(negedge clk);
    check("R5 link up at completion", {31'b0, link_up}, 32'h1);
    rd(5'd1, 16'h796D, 1'b0, "R5 status after completion");
    rd(5'd0, 16'h1200, 1'b0, "R9 control reads as written");

    // R3 and R12 reload
    wr(5'd0, 16'h1200, 1'b0, "R3 second trigger");
    rd(5'd1, 16'h7949, 1'b0, "R3 status during countdown");
    repeat (8) @(posedge clk);
    wr(5'd0, 16'h1200, 1'b0, "R12 retrigger");
    repeat (AN_N - 1) @(posedge clk);
    @(negedge clk);
    check("R12 down past first deadline", {31'b0, link_up}, 32'h0);
    @(posedge clk);
    @(negedge clk);
    check("R12 up after reloaded count", {31'b0, link_up}, 32'h1);

    // R6 reset cancels countdown
    wr(5'd0, 16'h1200, 1'b0, "R6 trigger before reset");
    repeat (5) @(posedge clk);
    pulse_reset();
    check("R6 link up after reset", {31'b0, link_up}, 32'h1);
    rd(5'd4, 16'h0DE1, 1'b0, "R6 advert reloaded");
    repeat (AN_N + 10) @(posedge clk);
    rd(5'd1, 16'h794D, 1'b0, "R6 no late completion");
    rd(5'd0, 16'h1140, 1'b0, "R6 control reloaded");

    repeat (3) @(negedge clk);
    if (exp_q.size() != 0) check("R10 responses outstanding", exp_q.size(), 32'h0);
    summary();
  end
endmodule